// File: doc/BRIEF.md
# Power-Good Reset Sequencer

This block turns a raw power-good input into an active-low reset for a processor. When power-good goes high, the block checks that supplies and clocks are reported stable. It then holds reset low for a fixed number of clock cycles, a count chosen so that the pulse falls inside a window of 1 to 10 ms. After that it releases reset. On the same clock edge that releases reset, the block latches a bus of configuration strap inputs. Those latched values stay fixed until the next power cycle.

Power-good may fall at any moment. When it does, reset asserts at once, with no clock needed, and all internal state clears. The next rise of power-good starts a complete new pulse. A bounce on power-good during the pulse therefore restarts the sequence. If power-good rises while the stable input reports that supplies or clocks are not yet good, the block raises a sequence-error flag. It then keeps reset asserted until power-good drops.

The raw power-good input passes through a two-flop synchronizer before the block acts on its rise. The hold count is a parameter. Elaboration stops when the count, including the synchronizer and evaluation latency, falls outside 1 to 10 ms at the declared clock rate in kHz.

Top module: `pg_rst_seq`

## Requirements
- R1: While pwr_good is low, rst_n, seq_err and strap_q all read 0. They take these values asynchronously, in the same time step that pwr_good falls, with no clock edge needed.
- R2: Number the clock edges from the first one that samples pwr_good high as edge 1. If supply_ok is high at edge 3, rst_n stays low through edge HOLD_CYCLES+2 and goes high at edge HOLD_CYCLES+3.
- R3: At the edge that releases rst_n, strap_q loads the value that strap_in has at that edge.
- R4: If supply_ok is low at edge 3, seq_err goes high at edge 3. From then on, seq_err stays high and rst_n stays low for as long as pwr_good stays high, whatever supply_ok does later.
- R5: If pwr_good falls at any point before release, the pulse is aborted. The next rise of pwr_good produces a full pulse timed as in R2.
- R6: Once rst_n is high, it stays high and strap_q does not change for as long as pwr_good stays high. Changes on strap_in and supply_ok have no effect during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| pwr_good | input | 1 | Raw power-good; low clears the block asynchronously |
| supply_ok | input | 1 | High when supplies and clocks are stable |
| strap_in | input | STRAP_W | Configuration strap inputs |
| rst_n | output | 1 | Active-low processor reset |
| strap_q | output | STRAP_W | Straps latched at reset release |
| seq_err | output | 1 | Power-good rose while supplies were not stable |

## Verification
A wrong state or count in this block shows up at rst_n as a release edge that comes one or more cycles early or late. That error is visible at edge HOLD_CYCLES+3 of every sequence. A synchronizer or clear path that keeps stale state after an abort shows up on the pulse that follows. The bench therefore aborts the sequence at every possible cycle and then times the next complete pulse. A capture taken on the wrong edge shows up in strap_q immediately after release, because strap_in changes one cycle before the release edge. Strap_in changes again right after release, so a capture that fires late or repeatedly is also visible.

// File: rtl/pg_rst_seq.sv
module pg_rst_seq #(
  parameter int CLK_KHZ     = 100000,
  parameter int HOLD_CYCLES = 250000,
  parameter int STRAP_W     = 8
) (
  input  logic               clk,
  input  logic               pwr_good,
  input  logic               supply_ok,
  input  logic [STRAP_W-1:0] strap_in,
  output logic               rst_n,
  output logic [STRAP_W-1:0] strap_q,
  output logic               seq_err
);
  localparam int CW        = $clog2(HOLD_CYCLES + 1);
  localparam int MIN_CYC   = CLK_KHZ;
  localparam int MAX_CYC   = 10 * CLK_KHZ;
  localparam int LATENCY   = 3;

  if (HOLD_CYCLES < MIN_CYC || HOLD_CYCLES + LATENCY > MAX_CYC) begin : g_bad_hold
    $error("pg_rst_seq: HOLD_CYCLES outside the 1 to 10 ms window");
  end

  typedef enum logic [1:0] {S_IDLE, S_COUNT, S_RUN, S_ERR} st_t;

  logic [1:0]    pg_sync;
  st_t           st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) pg_sync <= '0;
    else           pg_sync <= {pg_sync[0], 1'b1};

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      st      <= S_IDLE;
      cnt     <= '0;
      rst_n   <= 1'b0;
      strap_q <= '0;
      seq_err <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (pg_sync[1]) begin
            if (supply_ok) begin
              st  <= S_COUNT;
              cnt <= '0;
            end else begin
              st      <= S_ERR;
              seq_err <= 1'b1;
            end
          end
        S_COUNT:
          if (cnt == CW'(HOLD_CYCLES - 1)) begin
            st      <= S_RUN;
            rst_n   <= 1'b1;
            strap_q <= strap_in;
          end else begin
            cnt <= cnt + 1'b1;
          end
        default: ;
      endcase
    end
  end

  a_r3_capture_on_release: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(rst_n) |-> strap_q == $past(strap_in));

  a_r4_err_holds_reset: assert property (@(posedge clk) disable iff (!pwr_good)
    seq_err |-> !rst_n);

  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!pwr_good)
    seq_err |=> seq_err);

  a_r6_release_sticky: assert property (@(posedge clk) disable iff (!pwr_good)
    rst_n |=> rst_n);

  a_r6_straps_frozen: assert property (@(posedge clk) disable iff (!pwr_good)
    (rst_n && $past(rst_n)) |-> $stable(strap_q));

  a_r2_no_early_release: assert property (@(posedge clk) disable iff (!pwr_good)
    !pg_sync[1] |-> !rst_n);
endmodule

// File: tb/sim_pg_rst_seq.sv
module sim_pg_rst_seq;
  localparam int CLK_P = 10;
  localparam int KHZ   = 10;
  localparam int HOLD  = 20;
  localparam int SW    = 8;
  localparam int REL   = HOLD + 3;

  logic          clk = 1'b0;
  logic          pwr_good = 1'b0;
  logic          supply_ok = 1'b1;
  logic [SW-1:0] strap_in = '0;
  logic          rst_n;
  logic [SW-1:0] strap_q;
  logic          seq_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pg_rst_seq #(.CLK_KHZ(KHZ), .HOLD_CYCLES(HOLD), .STRAP_W(SW)) u0 (
    .clk(clk), .pwr_good(pwr_good), .supply_ok(supply_ok), .strap_in(strap_in),
    .rst_n(rst_n), .strap_q(strap_q), .seq_err(seq_err));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drop_pg();
    #2;
    pwr_good = 1'b0;
    #1;
    chk("R1", "rst_n after drop", int'(rst_n), 0);
    chk("R1", "seq_err after drop", int'(seq_err), 0);
    chk("R1", "strap_q after drop", int'(strap_q), 0);
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic run_full(input logic [SW-1:0] v, input bit ok);
    @(negedge clk);
    supply_ok = ok;
    strap_in  = ~v;
    pwr_good  = 1'b1;
    for (int e = 1; e <= REL + 2; e++) begin
      @(posedge clk);
      #1;
      if (ok) chk("R2", $sformatf("rst_n at edge %0d", e), int'(rst_n), (e >= REL) ? 1 : 0);
      else    chk("R4", $sformatf("rst_n held at edge %0d", e), int'(rst_n), 0);
      chk("R4", $sformatf("seq_err at edge %0d", e), int'(seq_err), (!ok && e >= 3) ? 1 : 0);
      if (e == REL - 1) strap_in = v;
      if (ok && e == REL) chk("R3", "strap_q at release", int'(strap_q), int'(v));
      if (e == REL + 1) begin
        strap_in  = v ^ 8'hA5;
        supply_ok = ~ok;
      end
      if (ok && e == REL + 2) begin
        chk("R6", "strap_q frozen", int'(strap_q), int'(v));
        chk("R6", "rst_n stays high", int'(rst_n), 1);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset rst_n", int'(rst_n), 0);
    chk("R1", "reset seq_err", int'(seq_err), 0);
    chk("R1", "reset strap_q", int'(strap_q), 0);

    for (int k = 1; k < REL; k++) begin
      @(negedge clk);
      supply_ok = 1'b1;
      pwr_good  = 1'b1;
      repeat (k) @(posedge clk);
      #1;
      chk("R5", $sformatf("rst_n low before abort k=%0d", k), int'(rst_n), 0);
      drop_pg();
      run_full(SW'(k * 11 + 3), 1'b1);
      drop_pg();
    end

    for (int p = 0; p < 256; p += 37) begin
      run_full(SW'(p), 1'b1);
      drop_pg();
    end

    run_full(8'h5A, 1'b0);
    supply_ok = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R4", "seq_err sticky after supply_ok", int'(seq_err), 1);
    chk("R4", "rst_n held after supply_ok", int'(rst_n), 0);
    drop_pg();
    run_full(8'h3C, 1'b1);
    drop_pg();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule